// File: doc/BRIEF.md
# Stream-Attached Function Unit

This block is a small function unit that hangs off a processor through two one-way point-to-point streams. One stream carries words into the unit and the other returns results. Every word is 32 bits wide and has one flag bit beside it. When the flag is set, the word is a control word. When the flag is clear, the word is a data word.

A control word chooses the operation the unit performs. The chosen operation stays in force until another control word arrives. Data words arrive in pairs. The first word of a pair is operand one and the second is operand two. Once the second operand is taken in, the unit computes the result and offers it on the output stream with the flag clear.

Both streams use a valid/ready handshake. A word moves only in a cycle where valid and ready are both high. Back-pressure works as follows:
- While a result is waiting on the output stream, the input stream holds ready low. A new pair therefore cannot overwrite a result that has not been delivered.
- While the output is stalled, the output data and valid stay unchanged.

Top module: `strm_coproc`

## Requirements
- R1: After a synchronous active-high reset, `m_valid` is 0 and `s_ready` is 1. The selected operation is addition, and the next data word is taken as operand one.
- R2: A control word (`s_ctrl`=1) selects the operation by its full 32-bit value: 0 add, 1 subtract (operand one minus operand two), 2 bitwise AND, 3 bitwise XOR, 4 shift operand one left by operand two bits [4:0]. Any other value makes the result 0.
- R3: Data words (`s_ctrl`=0) alternate between operand one and operand two. The result is the selected operation on the pair, taken modulo 2^32.
- R4: `m_valid` rises in the cycle after the handshake of operand two. One result is produced per pair, and no result appears without a pair.
- R5: While `m_valid` is 1 and `m_ready` is 0, `m_valid` stays 1 and `m_data` stays unchanged.
- R6: While `m_valid` is 1, `s_ready` is 0, and words offered on the input are not taken.
- R7: The selected operation persists across any number of pairs until a new control word arrives.
- R8: A control word that arrives when only operand one is held discards that operand. The next data word becomes operand one.
- R9: `m_ctrl` is 0 on every result.
- R10: `m_valid` falls in the cycle after an output handshake.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_data | input | 32 | Incoming word |
| s_ctrl | input | 1 | 1 marks the incoming word as control, 0 as data |
| s_valid | input | 1 | Incoming word is present |
| s_ready | output | 1 | Unit can take an incoming word |
| m_data | output | 32 | Result word |
| m_ctrl | output | 1 | Flag of the result word, always 0 (data) |
| m_valid | output | 1 | Result is present |
| m_ready | input | 1 | Consumer takes the result |

## Verification
Two things can land in the same cycle: an operation change and the dropping of a half-finished pair. Both happen when a control word arrives while operand one is held. The bench sends one operand under subtraction, then sends a control word that selects XOR, then sends a fresh pair. It passes only if the result is the XOR of the fresh pair. A result computed as a difference, or one that uses the stale operand, fails. A second collision is between a stalled output and a word offered on the input. The bench offers a control word during the stall and then shows, through the next result, that the word was not taken.

// File: rtl/strm_coproc_pkg.sv
package strm_coproc_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_AND  = 3'd2,
    OP_XOR  = 3'd3,
    OP_SHL  = 3'd4,
    OP_ZERO = 3'd5
  } op_e;
endpackage

// File: rtl/sc_steer.sv
module sc_steer
  import strm_coproc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_ctrl,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic              blocked,
  output op_e               op_sel,
  output logic [DATA_W-1:0] opnd_a,
  output logic [DATA_W-1:0] opnd_b,
  output logic              pair_done
);
  logic fire;
  logic have_a;
  op_e  decoded;

  assign s_ready = !blocked;
  assign fire    = s_valid && s_ready;

  // second operand goes straight to the function unit and result register
  assign opnd_b    = s_data;
  assign pair_done = fire && !s_ctrl && have_a;

  always_comb begin
    if (s_data == DATA_W'(0))      decoded = OP_ADD;
    else if (s_data == DATA_W'(1)) decoded = OP_SUB;
    else if (s_data == DATA_W'(2)) decoded = OP_AND;
    else if (s_data == DATA_W'(3)) decoded = OP_XOR;
    else if (s_data == DATA_W'(4)) decoded = OP_SHL;
    else                           decoded = OP_ZERO;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_sel <= OP_ADD;
      have_a <= 1'b0;
      opnd_a <= '0;
    end else if (fire) begin
      if (s_ctrl) begin
        op_sel <= decoded;
        have_a <= 1'b0;
      end else if (!have_a) begin
        opnd_a <= s_data;
        have_a <= 1'b1;
      end else begin
        have_a <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sc_func.sv
module sc_func
  import strm_coproc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  op_e               op_sel,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic [DATA_W-1:0] result
);
  localparam int SHW = $clog2(DATA_W);

  always_comb begin
    unique case (op_sel)
      OP_ADD:  result = opnd_a + opnd_b;
      OP_SUB:  result = opnd_a - opnd_b;
      OP_AND:  result = opnd_a & opnd_b;
      OP_XOR:  result = opnd_a ^ opnd_b;
      OP_SHL:  result = opnd_a << opnd_b[SHW-1:0];
      default: result = '0;
    endcase
  end
endmodule

// File: rtl/sc_hold.sv
module sc_hold #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              m_ready,
  output logic              m_valid,
  output logic [DATA_W-1:0] m_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else if (load) begin
      m_valid <= 1'b1;
      m_data  <= load_data;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/strm_coproc.sv
module strm_coproc
  import strm_coproc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_ctrl,
  input  logic              s_valid,
  output logic              s_ready,
  output logic [DATA_W-1:0] m_data,
  output logic              m_ctrl,
  output logic              m_valid,
  input  logic              m_ready
);
  op_e               op_sel;
  logic [DATA_W-1:0] opnd_a;
  logic [DATA_W-1:0] opnd_b;
  logic [DATA_W-1:0] result;
  logic              pair_done;

  sc_steer #(.DATA_W(DATA_W)) u_steer (
    .clk(clk), .rst(rst), .s_data(s_data), .s_ctrl(s_ctrl),
    .s_valid(s_valid), .s_ready(s_ready), .blocked(m_valid),
    .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .pair_done(pair_done)
  );

  sc_func #(.DATA_W(DATA_W)) u_func (
    .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result)
  );

  sc_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst(rst), .load(pair_done), .load_data(result),
    .m_ready(m_ready), .m_valid(m_valid), .m_data(m_data)
  );

  assign m_ctrl = 1'b0;
endmodule

// File: rtl/strm_coproc_chk.sv
module strm_coproc_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              s_ready,
  input logic              m_valid,
  input logic              m_ready,
  input logic [DATA_W-1:0] m_data,
  input logic              pair_done
);
  AST_RESET_IDLE: assert property (@(posedge clk) $past(rst) |-> (!m_valid && s_ready)); // R1
  AST_PAIR_TO_VALID: assert property (@(posedge clk) disable iff (rst) pair_done |=> m_valid); // R4
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst) (!pair_done && !m_valid) |=> !m_valid); // R4
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst) (m_valid && !m_ready) |=> (m_valid && $stable(m_data))); // R5
  AST_BLOCK_INPUT: assert property (@(posedge clk) disable iff (rst) m_valid |-> !s_ready); // R6
  AST_DROP_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst) (m_valid && m_ready) |=> !m_valid); // R10
endmodule

bind strm_coproc strm_coproc_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .s_ready(s_ready), .m_valid(m_valid),
  .m_ready(m_ready), .m_data(m_data), .pair_done(pair_done)
);

// File: tb/strm_coproc_tb.sv
module strm_coproc_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] s_data = '0;
  logic        s_ctrl = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [31:0] m_data;
  logic        m_ctrl;
  logic        m_valid;
  logic        m_ready = 1'b0;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  strm_coproc u_dut (
    .clk(clk), .rst(rst), .s_data(s_data), .s_ctrl(s_ctrl),
    .s_valid(s_valid), .s_ready(s_ready), .m_data(m_data),
    .m_ctrl(m_ctrl), .m_valid(m_valid), .m_ready(m_ready)
  );

  typedef struct packed {
    logic [31:0] code;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{32'd0, 32'd5,          32'd7,          32'h0000000C},
    '{32'd0, 32'hFFFFFFFF,   32'd2,          32'h00000001},
    '{32'd1, 32'd3,          32'd5,          32'hFFFFFFFE},
    '{32'd1, 32'd10,         32'd4,          32'h00000006},
    '{32'd2, 32'hF0F0F0F0,   32'h0FF00FF0,   32'h00F000F0},
    '{32'd3, 32'hAAAAAAAA,   32'hFFFF0000,   32'h5555AAAA},
    '{32'd4, 32'd1,          32'h0000001F,   32'h80000000},
    '{32'd4, 32'd3,          32'h00000024,   32'h00000030},
    '{32'd5, 32'd1,          32'd1,          32'h00000000},
    '{32'h100, 32'd2,        32'd3,          32'h00000000}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] w, input logic c);
    @(negedge clk);
    s_data = w; s_ctrl = c; s_valid = 1'b1;
    while (!s_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  // second operand: check R4 timing at the negedge after its handshake
  task automatic send_last(input logic [31:0] w, input string req);
    send(w, 1'b0);
    chk(m_valid === 1'b1, req, {31'd0, m_valid}, 32'd1);
  endtask

  task automatic recv(input logic [31:0] exp, input string req);
    int guard = 0;
    while (!m_valid && guard < 50) begin @(negedge clk); guard++; end
    chk(m_data === exp, req, m_data, exp);
    chk(m_ctrl === 1'b0, "R9", {31'd0, m_ctrl}, 32'd0);
    m_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    m_ready = 1'b0;
    chk(m_valid === 1'b0, "R10", {31'd0, m_valid}, 32'd0);
  endtask

  initial begin
    #(20 * 100000);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle state after reset
    chk(m_valid === 1'b0, "R1", {31'd0, m_valid}, 32'd0);
    chk(s_ready === 1'b1, "R1", {31'd0, s_ready}, 32'd1);
    // R1: default operation is add
    send(32'd4, 1'b0);
    send_last(32'd5, "R4");
    recv(32'd9, "R1");

    // R2 R3: table walk
    for (int i = 0; i < NV; i++) begin
      send(VECS[i].code, 1'b1);
      send(VECS[i].a, 1'b0);
      send_last(VECS[i].b, "R4");
      recv(VECS[i].exp, "R2/R3");
    end

    // R7: subtract persists over two pairs
    send(32'd1, 1'b1);
    send(32'd20, 1'b0); send_last(32'd8, "R4"); recv(32'd12, "R7");
    send(32'd9, 1'b0);  send_last(32'd9, "R4"); recv(32'd0, "R7");

    // R8: control word drops a lone operand
    send(32'd100, 1'b0);
    send(32'd3, 1'b1);
    send(32'd6, 1'b0); send_last(32'd3, "R4"); recv(32'd5, "R8");

    // R5 R6: stall the output, offer a control word meanwhile
    send(32'd0, 1'b1);
    send(32'd11, 1'b0); send_last(32'd22, "R4");
    @(negedge clk);
    s_data = 32'd2; s_ctrl = 1'b1; s_valid = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(m_valid === 1'b1 && m_data === 32'd33, "R5", m_data, 32'd33);
      chk(s_ready === 1'b0, "R6", {31'd0, s_ready}, 32'd0);
    end
    s_valid = 1'b0;
    recv(32'd33, "R5");
    // the offered control word (AND) must not have been taken: still add
    send(32'd6, 1'b0); send_last(32'd3, "R4"); recv(32'd9, "R6");

    // R4: no result after a single operand
    send(32'd1, 1'b0);
    repeat (3) @(negedge clk);
    chk(m_valid === 1'b0, "R4", {31'd0, m_valid}, 32'd0);
    send_last(32'd1, "R4"); recv(32'd2, "R3");

    // R1: reset mid-pair restores add and operand order
    send(32'd3, 1'b1);
    send(32'd50, 1'b0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(m_valid === 1'b0 && s_ready === 1'b1, "R1", {31'd0, m_valid}, 32'd0);
    send(32'd7, 1'b0); send_last(32'd8, "R4"); recv(32'd15, "R1");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule